// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block runs PHY management transactions on a two-wire management bus. A host programs a 32-bit control word and, for extended accesses, a 32-bit extension word. Setting the start bit launches a frame. The block derives the management clock from its 25 MHz reference clock through a selectable divider, drives the data line, and releases the line while the PHY answers a read. The host polls a busy flag, then collects the read result from the low half of the control word.

Two access styles share the control word. In a direct access a 5-bit register number is sent to PHY address 0. In an extended access an address frame first carries the port, device and a 16-bit register address, and a data frame follows. An auto-poll mode keeps reading PHY register 1 in the background whenever no host transaction is pending. The host enters it by writing the control word with auto-poll set and start clear.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both register read-backs are zero, MDC is low and the master does not drive MDIO (output enable low).
- R2: Writing the control word with bit 23 set starts a transaction. Busy (bit 27) reads 1 until the last frame of the transaction ends, and bit 23 always reads 0. Bits 30:28, 26:24 and 22:0 read back as last accepted.
- R3: A direct frame is 32 preamble ones, omitted when bit 22 is set, then start 01, opcode 10 for read (bit 21 = 1) or 01 for write, PHY address 00000, the register number from bits 20:16, turnaround 10, and 16 data bits MSB first. Write data comes from bits 15:0.
- R4: On a read, the master releases MDIO from the 15th frame bit (the turnaround) to the end of the frame. It samples the 16 data bits on rising MDC edges and places them in bits 15:0 when busy clears.
- R5: Bits 26:24 set the MDC period in reference cycles: code 0 or 1 gives 4, 2 gives 6, 3 gives 8, 4 gives 10, 5 gives 32, 6 gives 64 and 7 gives 128. MDC is low between frames. MDIO changes only while MDC is low.
- R6: With bit 30 set, the master first sends an address frame: start 00, opcode 00, port (extension bits 25:21), device (extension bits 20:16), turnaround 10, register address (extension bits 15:0). It then sends a data frame with start 00, opcode 11 for read or 01 for write, and the same port and device. Busy stays 1 across both frames.
- R7: While busy is 1, writes to the control word and to the extension word are ignored.
- R8: While bit 28 is set and busy is 0, the master repeatedly reads PHY register 1 as a direct read. Each result lands in bits 15:0, and busy stays 0.
- R9: Clearing bit 28 lets a poll frame already in progress finish. After that no further frame starts.
- R10: A complete direct read with code 7 and preamble ends within 30000 reference cycles (1.2 ms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word to write |
| ext_wr | input | 1 | Write strobe for the extension word |
| ext_wdata | input | 32 | Extension word to write |
| ctl_rdata | output | 32 | Control word read-back (busy, fields, read data) |
| ext_rdata | output | 32 | Extension word read-back |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, a 32-bit frame and 16 data bits. At these values every divider code, including the slowest, fits within the run, so the MDC period can be measured for each code and the 1.2 ms bound checked at the /128 setting. A behavioural PHY on the bench side decodes each frame's preamble length, start, opcode and address fields. It answers reads and records writes, so direct, extended and auto-poll traffic are all checked against values the bench sets up.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;

  localparam int HALF_W = 7;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR_GO,
    SQ_ADDR_RUN,
    SQ_DATA_GO,
    SQ_DATA_RUN,
    SQ_POLL_RUN
  } seq_t;

  typedef struct packed {
    logic        ext;
    logic        post;
    logic        ap;
    logic [2:0]  csel;
    logic        supp;
    logic        rd;
    logic [4:0]  regn;
    logic [15:0] data;
  } ctl_t;

  // Half of the MDC period in reference cycles for each divider code.
  function automatic logic [HALF_W-1:0] half_of(input logic [2:0] code);
    case (code)
      3'd2:    half_of = 7'd3;
      3'd3:    half_of = 7'd4;
      3'd4:    half_of = 7'd5;
      3'd5:    half_of = 7'd16;
      3'd6:    half_of = 7'd32;
      3'd7:    half_of = 7'd64;
      default: half_of = 7'd2;
    endcase
  endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic              term;

  assign term = run && (cnt_q == half - HALF_W'(1));
  assign rise = term && !mdc_q;
  assign fall = term && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R5: a rising tick always leaves MDC high on the next cycle
  a_r5_rise_sets_mdc: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> mdc_q);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgr_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int TA_POS  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [FRAME_W-1:0] word,
  input  logic               is_read,
  input  logic               skip_pre,
  input  logic [2:0]         csel,
  input  logic               mdio_i,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);
  localparam int CNT_W    = $clog2(PRE_LEN + FRAME_W + 1);
  localparam int DATA_POS = FRAME_W - DATA_W;

  logic               act_q, act_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   pre_q, pre_d;
  logic               rd_q, rd_d;
  logic [HALF_W-1:0]  half_q, half_d;
  logic               out_q, out_d;
  logic               oe_q, oe_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic               rise, fall, last;
  logic [CNT_W-1:0]   pre_new;

  mdc_divider #(.HALF_W(HALF_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (act_q),
    .half (half_q),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  assign pre_new = skip_pre ? '0 : CNT_W'(PRE_LEN);
  assign last    = fall && (cnt_q == pre_q + CNT_W'(FRAME_W));
  assign done    = last;
  assign rdata   = rx_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;

  always_comb begin
    act_d  = act_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    rd_d   = rd_q;
    half_d = half_q;
    out_d  = out_q;
    oe_d   = oe_q;
    rx_d   = rx_q;
    if (launch) begin
      act_d  = 1'b1;
      sh_d   = word;
      cnt_d  = '0;
      pre_d  = pre_new;
      rd_d   = is_read;
      half_d = half_of(csel);
      out_d  = (pre_new == '0) ? word[FRAME_W-1] : 1'b1;
      oe_d   = 1'b1;
    end else if (act_q) begin
      if (rise) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (rd_q && cnt_q >= pre_q + CNT_W'(DATA_POS))
          rx_d = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall) begin
        if (last) begin
          act_d = 1'b0;
          oe_d  = 1'b0;
          out_d = 1'b1;
        end else begin
          if (cnt_q < pre_q) begin
            out_d = 1'b1;
          end else if (cnt_q == pre_q) begin
            out_d = sh_q[FRAME_W-1];
          end else begin
            sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
            out_d = sh_q[FRAME_W-2];
          end
          oe_d = !(rd_q && cnt_q >= pre_q + CNT_W'(TA_POS));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      rd_q   <= 1'b0;
      half_q <= HALF_W'(2);
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
      rd_q   <= rd_d;
      half_q <= half_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      rx_q   <= rx_d;
    end
  end

  // R5: MDC rests low whenever no frame is running
  a_r5_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !mdc);

  // R4: line released from turnaround to frame end on reads
  a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rd_q && cnt_q > pre_q + CNT_W'(TA_POS)) |-> !oe_q);

  // R3: bit counter never runs past the frame
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= pre_q + CNT_W'(FRAME_W)));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgr_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        ext_wr,
  input  logic [31:0] ext_wdata,
  output logic [31:0] ctl_rdata,
  output logic [31:0] ext_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;

  ctl_t        ctl_q, ctl_d;
  logic        busy_q, busy_d;
  logic [4:0]  prt_q, prt_d, dev_q, dev_d;
  logic [15:0] xad_q, xad_d;
  seq_t        st_q, st_d;

  logic               launch, word_rd, eng_done;
  logic [FRAME_W-1:0] word;
  logic [DATA_W-1:0]  eng_rdata;
  logic [FRAME_W-1:0] direct_w, xaddr_w, xdata_w, poll_w;

  assign direct_w = {2'b01, (ctl_q.rd ? 2'b10 : 2'b01), 5'd0, ctl_q.regn, 2'b10, ctl_q.data};
  assign xaddr_w  = {4'b0000, prt_q, dev_q, 2'b10, xad_q};
  assign xdata_w  = {2'b00, (ctl_q.rd ? 2'b11 : 2'b01), prt_q, dev_q, 2'b10, ctl_q.data};
  assign poll_w   = {2'b01, 2'b10, 5'd0, 5'd1, 2'b10, 16'hFFFF};

  always_comb begin
    ctl_d   = ctl_q;
    busy_d  = busy_q;
    prt_d   = prt_q;
    dev_d   = dev_q;
    xad_d   = xad_q;
    st_d    = st_q;
    launch  = 1'b0;
    word    = direct_w;
    word_rd = ctl_q.rd;
    case (st_q)
      SQ_IDLE: begin
        if (busy_q) begin
          st_d = ctl_q.ext ? SQ_ADDR_GO : SQ_DATA_GO;
        end else if (ctl_q.ap) begin
          launch  = 1'b1;
          word    = poll_w;
          word_rd = 1'b1;
          st_d    = SQ_POLL_RUN;
        end
      end
      SQ_ADDR_GO: begin
        launch  = 1'b1;
        word    = xaddr_w;
        word_rd = 1'b0;
        st_d    = SQ_ADDR_RUN;
      end
      SQ_ADDR_RUN: if (eng_done) st_d = SQ_DATA_GO;
      SQ_DATA_GO: begin
        launch = 1'b1;
        word   = ctl_q.ext ? xdata_w : direct_w;
        st_d   = SQ_DATA_RUN;
      end
      SQ_DATA_RUN: begin
        if (eng_done) begin
          busy_d = 1'b0;
          if (ctl_q.rd) ctl_d.data = eng_rdata;
          st_d = SQ_IDLE;
        end
      end
      SQ_POLL_RUN: begin
        if (eng_done) begin
          if (!busy_q) ctl_d.data = eng_rdata;
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    if (ctl_wr && !busy_q) begin
      ctl_d.ext  = ctl_wdata[30];
      ctl_d.post = ctl_wdata[29];
      ctl_d.ap   = ctl_wdata[28];
      ctl_d.csel = ctl_wdata[26:24];
      ctl_d.supp = ctl_wdata[22];
      ctl_d.rd   = ctl_wdata[21];
      ctl_d.regn = ctl_wdata[20:16];
      ctl_d.data = ctl_wdata[15:0];
      busy_d     = ctl_wdata[23];
    end
    if (ext_wr && !busy_q) begin
      prt_d = ext_wdata[25:21];
      dev_d = ext_wdata[20:16];
      xad_d = ext_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      busy_q <= 1'b0;
      prt_q  <= '0;
      dev_q  <= '0;
      xad_q  <= '0;
      st_q   <= SQ_IDLE;
    end else begin
      ctl_q  <= ctl_d;
      busy_q <= busy_d;
      prt_q  <= prt_d;
      dev_q  <= dev_d;
      xad_q  <= xad_d;
      st_q   <= st_d;
    end
  end

  mdio_frame_engine #(
    .FRAME_W(FRAME_W),
    .PRE_LEN(PRE_LEN),
    .DATA_W (DATA_W),
    .TA_POS (14)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .word    (word),
    .is_read (word_rd),
    .skip_pre(ctl_q.supp),
    .csel    (ctl_q.csel),
    .mdio_i  (mdio_i),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (eng_done),
    .rdata   (eng_rdata)
  );

  assign ctl_rdata = {1'b0, ctl_q.ext, ctl_q.post, ctl_q.ap, busy_q, ctl_q.csel,
                      1'b0, ctl_q.supp, ctl_q.rd, ctl_q.regn, ctl_q.data};
  assign ext_rdata = {6'd0, prt_q, dev_q, xad_q};

  // R7: a write arriving while busy leaves the accepted fields untouched
  a_r7_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_wr) |=> ($stable(ctl_q.regn) && $stable(ctl_q.csel) && $stable(ctl_q.ext)));

  // R6: busy only drops at the end of the data frame
  a_r6_busy_spans_frames: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(st_q) == SQ_DATA_RUN));

  // R2: busy only rises from an accepted host write
  a_r2_busy_from_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ctl_wr));

endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int CLK_PERIOD = 40;
  localparam int WD_LIMIT   = 150000;

  logic        clk, rst_n;
  logic        ctl_wr, ext_wr;
  logic [31:0] ctl_wdata, ext_wdata, ctl_rdata, ext_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;
  logic        phy_en, phy_bit;

  int total, bad;
  bit finished;

  // PHY model state
  logic [15:0] dmem [32];
  logic [15:0] xmem [16];
  logic [13:0] hdr, last_hdr;
  logic [15:0] wsh, rd_val, x_addr;
  bit  in_frame, rd_frame;
  int  n, pre_ones, start_pre, last_pre, frames, oe_err;
  int  ccount, last_period;
  logic mdc_d;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_master dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ctl_rdata(ctl_rdata),
    .ext_rdata(ext_rdata), .mdio_i(mdio_line), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // MDC period monitor
  always @(posedge clk) begin
    ccount <= ccount + 1;
    mdc_d  <= mdc;
    if (mdc && !mdc_d) begin
      last_period <= ccount;
      ccount <= 1;
    end
  end

  // Behavioural PHY: decodes frames on rising MDC, answers reads
  always @(posedge mdc) begin
    logic b;
    b = mdio_line;
    if (!in_frame) begin
      if (b) pre_ones++;
      else begin
        in_frame  = 1;
        n         = 1;
        hdr       = {13'd0, b};
        start_pre = pre_ones;
        pre_ones  = 0;
      end
    end else begin
      n++;
      if (n <= 14) hdr = {hdr[12:0], b};
      else if (n >= 17) wsh = {wsh[14:0], b};
      if (n == 14) begin
        rd_frame = (hdr[13:10] == 4'b0110) || (hdr[13:10] == 4'b0011);
        rd_val   = (hdr[13:12] == 2'b00) ? xmem[x_addr[3:0]] : dmem[hdr[4:0]];
      end
      if (n == 14 && !mdio_oe) oe_err++;
      if (n >= 15 && rd_frame && mdio_oe) oe_err++;
      if (n >= 15 && !rd_frame && !mdio_oe) oe_err++;
      if (rd_frame && n >= 15 && n <= 31) begin
        phy_en  <= 1'b1;
        phy_bit <= (n == 15) ? 1'b0 : rd_val[31-n];
      end
      if (n == 32) begin
        phy_en <= 1'b0;
        if (hdr[13:10] == 4'b0000) x_addr = wsh;
        else if (hdr[13:10] == 4'b0101) dmem[hdr[4:0]] = wsh;
        else if (hdr[13:10] == 4'b0001) xmem[x_addr[3:0]] = wsh;
        last_hdr = hdr;
        last_pre = start_pre;
        in_frame = 0;
        rd_frame = 0;
        frames++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit ext, input bit ap, input int csel,
                                     input bit start, input bit supp, input bit rd,
                                     input int regn, input int data);
    mk = {1'b0, ext, 1'b0, ap, 1'b0, 3'(csel), start, supp, rd, 5'(regn), 16'(data)};
  endfunction

  function automatic int period_of(input int code);
    case (code)
      2: period_of = 6;   3: period_of = 8;   4: period_of = 10;
      5: period_of = 32;  6: period_of = 64;  7: period_of = 128;
      default: period_of = 4;
    endcase
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_ext(input logic [31:0] v);
    @(negedge clk); ext_wr = 1'b1; ext_wdata = v;
    @(negedge clk); ext_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (ctl_rdata[27] && cyc < 40000) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic wait_frames(input int target);
    int g;
    g = 0;
    while (frames < target && g < 40000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic t_reset();
    chk(ctl_rdata == 32'd0, "R1 ctl reset", ctl_rdata, 0);
    chk(ext_rdata == 32'd0, "R1 ext reset", ext_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_direct_write();
    int c;
    wr_ctl(mk(0, 0, 0, 1, 0, 0, 5, 16'hBEEF));
    chk(ctl_rdata[27] == 1'b1, "R2 busy set", ctl_rdata[27], 1);
    chk(ctl_rdata[23] == 1'b0, "R2 start reads 0", ctl_rdata[23], 0);
    wait_idle(c);
    chk(dmem[5] == 16'hBEEF, "R3 write data", dmem[5], 16'hBEEF);
    chk(last_hdr == {2'b01, 2'b01, 5'd0, 5'd5}, "R3 write header", last_hdr, {2'b01, 2'b01, 5'd0, 5'd5});
    chk(last_pre == 32, "R3 preamble length", last_pre, 32);
    chk(last_period == 4, "R5 code0 period", last_period, 4);
    chk(ctl_rdata[20:16] == 5'd5 && ctl_rdata[15:0] == 16'hBEEF, "R2 readback", ctl_rdata, 32'h0005BEEF);
    chk(mdc == 1'b0, "R5 mdc low after frame", mdc, 0);
  endtask

  task automatic t_direct_read();
    int c, e0;
    e0 = oe_err;
    wr_ctl(mk(0, 0, 0, 1, 1, 1, 9, 0));
    wait_idle(c);
    chk(ctl_rdata[15:0] == 16'h1234, "R4 read data", ctl_rdata[15:0], 16'h1234);
    chk(last_pre == 0, "R3 suppressed preamble", last_pre, 0);
    chk(last_hdr == {2'b01, 2'b10, 5'd0, 5'd9}, "R3 read header", last_hdr, {2'b01, 2'b10, 5'd0, 5'd9});
    chk(oe_err == e0, "R4 turnaround release", oe_err, e0);
  endtask

  task automatic t_dividers();
    int c;
    for (int code = 1; code <= 6; code++) begin
      wr_ctl(mk(0, 0, code, 1, 1, 1, 9, 0));
      wait_idle(c);
      chk(last_period == period_of(code), "R5 divider period", last_period, period_of(code));
    end
  endtask

  task automatic t_extended();
    int c, f0;
    wr_ext({6'd0, 5'd3, 5'd7, 16'h0042});
    chk(ext_rdata == {6'd0, 5'd3, 5'd7, 16'h0042}, "R6 ext readback", ext_rdata, {6'd0, 5'd3, 5'd7, 16'h0042});
    f0 = frames;
    wr_ctl(mk(1, 0, 0, 1, 0, 0, 0, 16'h5A5A));
    wait_frames(f0 + 1);
    @(negedge clk);
    chk(ctl_rdata[27] == 1'b1, "R6 busy between frames", ctl_rdata[27], 1);
    chk(last_hdr == {4'b0000, 5'd3, 5'd7}, "R6 address frame", last_hdr, {4'b0000, 5'd3, 5'd7});
    chk(x_addr == 16'h0042, "R6 register address", x_addr, 16'h0042);
    wait_idle(c);
    chk(frames == f0 + 2, "R6 two frames", frames, f0 + 2);
    chk(last_hdr == {4'b0001, 5'd3, 5'd7}, "R6 write data frame", last_hdr, {4'b0001, 5'd3, 5'd7});
    chk(xmem[2] == 16'h5A5A, "R6 ext write value", xmem[2], 16'h5A5A);
    wr_ctl(mk(1, 0, 0, 1, 1, 1, 0, 0));
    wait_idle(c);
    chk(last_hdr == {4'b0011, 5'd3, 5'd7}, "R6 read data frame", last_hdr, {4'b0011, 5'd3, 5'd7});
    chk(ctl_rdata[15:0] == 16'h5A5A, "R6 ext read value", ctl_rdata[15:0], 16'h5A5A);
  endtask

  task automatic t_busy_ignore();
    int c, f0;
    f0 = frames;
    wr_ctl(mk(0, 0, 2, 1, 0, 0, 4, 16'h1111));
    wr_ctl(mk(0, 0, 0, 1, 0, 0, 8, 16'h2222));
    wr_ext({6'd0, 5'd1, 5'd1, 16'h0001});
    wait_idle(c);
    chk(ctl_rdata[20:16] == 5'd4 && ctl_rdata[26:24] == 3'd2, "R7 ctl unchanged", ctl_rdata, 0);
    chk(dmem[4] == 16'h1111, "R7 first write done", dmem[4], 16'h1111);
    chk(dmem[8] == 16'h0808, "R7 second write ignored", dmem[8], 16'h0808);
    chk(ext_rdata == {6'd0, 5'd3, 5'd7, 16'h0042}, "R7 ext unchanged", ext_rdata, {6'd0, 5'd3, 5'd7, 16'h0042});
    chk(frames == f0 + 1, "R7 one frame", frames, f0 + 1);
  endtask

  task automatic t_autopoll();
    int c, f0, f1;
    wr_ctl(mk(0, 0, 0, 1, 1, 1, 1, 0));
    wait_idle(c);
    chk(ctl_rdata[15:0] == 16'h7809, "R8 initial reg1 read", ctl_rdata[15:0], 16'h7809);
    wr_ctl(mk(0, 1, 0, 0, 1, 1, 1, 0));
    f0 = frames;
    wait_frames(f0 + 3);
    chk(frames >= f0 + 3, "R8 polling runs", frames, f0 + 3);
    chk(last_hdr == {2'b01, 2'b10, 5'd0, 5'd1}, "R8 poll reads reg1", last_hdr, {2'b01, 2'b10, 5'd0, 5'd1});
    dmem[1] = 16'h782D;
    wait_frames(frames + 2);
    @(negedge clk);
    chk(ctl_rdata[15:0] == 16'h782D, "R8 poll result", ctl_rdata[15:0], 16'h782D);
    chk(ctl_rdata[27] == 1'b0, "R8 busy stays low", ctl_rdata[27], 0);
    wait_frames(frames + 1);
    repeat (20) @(negedge clk);
    wr_ctl(mk(0, 0, 0, 0, 1, 1, 1, 0));
    repeat (300) @(negedge clk);
    f1 = frames;
    repeat (600) @(negedge clk);
    chk(frames == f1, "R9 no frames after clear", frames, f1);
    chk(!in_frame && mdc == 1'b0, "R9 frame completed", in_frame, 0);
  endtask

  task automatic t_slow();
    int c;
    wr_ctl(mk(0, 0, 7, 1, 0, 1, 9, 0));
    wait_idle(c);
    chk(c < 30000, "R10 slow transaction time", c, 30000);
    chk(last_period == 128, "R5 code7 period", last_period, 128);
    chk(ctl_rdata[15:0] == 16'h1234, "R10 slow read data", ctl_rdata[15:0], 16'h1234);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WD_LIMIT, WD_LIMIT);
    finish_run();
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    in_frame = 0; rd_frame = 0; n = 0; pre_ones = 0; start_pre = 0;
    last_pre = -1; frames = 0; oe_err = 0; ccount = 0; last_period = 0;
    mdc_d = 0; phy_en = 0; phy_bit = 1; x_addr = 0; hdr = 0; last_hdr = 0;
    wsh = 0; rd_val = 0;
    for (int i = 0; i < 32; i++) dmem[i] = 16'(i * 257);
    for (int i = 0; i < 16; i++) xmem[i] = 16'hC000 | 16'(i);
    dmem[9] = 16'h1234;
    dmem[1] = 16'h7809;
    ctl_wr = 0; ext_wr = 0; ctl_wdata = 0; ext_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_direct_write();
    t_direct_read();
    t_dividers();
    t_extended();
    t_busy_ignore();
    t_autopoll();
    t_slow();
    chk(oe_err == 0, "R4 output enable pattern", oe_err, 0);
    finish_run();
  end

endmodule